// File: doc/BRIEF.md
# Reset Cause and Soft Reset Request Register

This block is a single 32-bit register on a simple register bus. It records why the system last came out of reset and lets software ask for a new reset. The register sits in an eight-byte window at a parameterised base, 0xF020 by default. Only the upper word of that window, where address bit 2 is set, holds the register.

Three status flags report causes: a power-on flag and two flags for button-initiated resets. Software clears each of these by writing a one. Two request flags stay set once software writes a one to them. Writing a one to either request flag sends a one-cycle pulse to the system reset logic. A power-on request also re-arms the internal boot counter, so the next system reset counts as a power-on.

A system-reset input marks each reset that the sequencer applies. The first such reset after power-up, or after a power-on request, loads the register with only the power-on flag set. Later system resets leave the register as it is.

Top module: `rst_cause_reg`

## Requirements
- R1: After the synchronous active-low `rst_n`, a read of the register returns 0 and `rst_req` is 0.
- R2: A `sys_rst` cycle while the boot counter is zero loads the register with exactly 0x8000_0000 (bit 31 only). A `sys_rst` cycle while the counter is non-zero leaves the register unchanged. Each `sys_rst` increments the counter.
- R3: Writing a one to bit 31 (power-on), bit 28 (button power-on) or bit 27 (button external reset) clears that bit. Writing a zero to any of them leaves it unchanged.
- R4: Writing a one to bit 30 (soft power-on) or bit 29 (soft external reset) sets that bit. Writing a zero to either leaves it unchanged.
- R5: Bits 26:0 always read 0, and write data in those bits has no effect.
- R6: A write with bit 30 set raises `rst_req` for one cycle, starting on the clock edge after the write. It also clears the boot counter, so the next `sys_rst` loads 0x8000_0000.
- R7: A write with bit 29 set and bit 30 clear raises `rst_req` in the same way but leaves the boot counter alone.
- R8: `rst_req` is high for exactly one cycle per request. It stays low after any write that has both bits 30 and 29 clear.
- R9: A write takes effect only when `bus_sel` and `bus_wr` are high, `bus_addr[2]` is 1 and `bus_addr[ADDR_W-1:3]` matches the base. A read returns the register under the same address match. Every other read returns 0, and every other write is ignored.
- R10: `btn_por` sets bit 28 and `btn_xir` sets bit 27 on the next clock. A button set takes priority over a clear written in the same cycle.
- R11: The boot counter saturates at 2^CNT_W-1 and never wraps, so repeated `sys_rst` never reloads the power-on value by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset of the block |
| sys_rst | input | 1 | One cycle per system reset applied by the sequencer |
| btn_por | input | 1 | Button power-on reset event |
| btn_xir | input | 1 | Button external reset event |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with CNT_W = 2, so the boot counter saturates at 3. This puts saturation, and the point where a wrapping counter would falsely reload the power-on value, within a handful of system resets. The default base address is kept, so the decoder sees both the real window and addresses just beside it. A behavioural model is compared with the read data and the request pulse on every clock.

// File: rtl/rcr_pkg.sv
// Shared bit positions and masks for the reset cause register.
// Assumes a 32-bit data word; bit positions are fixed by software.
package rcr_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned B_POR    = 31;
    localparam int unsigned B_SPOR   = 30;
    localparam int unsigned B_SXIR   = 29;
    localparam int unsigned B_BPOR   = 28;
    localparam int unsigned B_BXIR   = 27;
    localparam logic [DATA_W-1:0] M_W1C = (32'd1 << B_POR) | (32'd1 << B_BPOR) | (32'd1 << B_BXIR);
    localparam logic [DATA_W-1:0] M_W1S = (32'd1 << B_SPOR) | (32'd1 << B_SXIR);
    localparam logic [DATA_W-1:0] POR_ONLY = 32'd1 << B_POR;
endpackage

// File: rtl/rcr_decode.sv
// Address decoder: matches the 8-byte window at BASE_ADDR and selects
// the upper word (address bit 2 set). Assumes BASE_ADDR is 8-byte aligned.
module rcr_decode #(
    parameter int unsigned ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_hit,
    output logic              rd_hit
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(7);
    localparam logic [ADDR_W-1:0] WORD_SEL = ADDR_W'(4);

    logic in_win;

    // Window match plus upper-word select
    always_comb begin
        in_win = ((addr & ~LOW_MASK) == (BASE_ADDR & ~LOW_MASK)) && ((addr & WORD_SEL) != '0);
        wr_hit = sel && wr && in_win;
        rd_hit = sel && !wr && in_win;
    end
endmodule

// File: rtl/rcr_boot_count.sv
// Counts system resets since power-up or since the last soft power-on
// request; saturates at its maximum. first_boot flags a zero count.
module rcr_boot_count #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_rst,
    input  logic             rearm,
    output logic             first_boot,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // Re-arm wins over counting; count stops at CNT_MAX
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (rearm)                      cnt_q <= '0;
        else if (sys_rst && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign first_boot = (cnt_q == '0);
    assign cnt        = cnt_q;
endmodule

// File: rtl/rcr_status.sv
// Status/request word: power-on load, write-one-to-clear cause bits,
// write-one-to-set request bits, then button sets (highest priority).
module rcr_status
    import rcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_por,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              btn_por,
    input  logic              btn_xir,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] q_r, nxt;

    // Next-state merge in priority order
    always_comb begin
        nxt = load_por ? POR_ONLY : q_r;
        if (wr_en) begin
            nxt = nxt & ~(wdata & M_W1C);
            nxt = nxt | (wdata & M_W1S);
        end
        if (btn_por) nxt[B_BPOR] = 1'b1;
        if (btn_xir) nxt[B_BXIR] = 1'b1;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= nxt;
    end

    assign q = q_r;
endmodule

// File: rtl/rst_cause_reg.sv
// Top: reset cause / soft reset request register on a register bus.
// Assumes single-cycle bus accesses and a one-cycle sys_rst per reset.
module rst_cause_reg
    import rcr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020,
    parameter int unsigned CNT_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_rst,
    input  logic              btn_por,
    input  logic              btn_xir,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              rst_req
);
    logic             wr_hit, rd_hit, first_boot, soft_por, req_set;
    logic [CNT_W-1:0] boot_cnt;
    logic [31:0]      status_q;

    rcr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
        .wr_hit(wr_hit), .rd_hit(rd_hit)
    );

    assign soft_por = wr_hit && bus_wdata[B_SPOR];
    assign req_set  = wr_hit && (bus_wdata[B_SPOR] || bus_wdata[B_SXIR]);

    rcr_boot_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .rearm(soft_por),
        .first_boot(first_boot), .cnt(boot_cnt)
    );

    rcr_status u_stat (
        .clk(clk), .rst_n(rst_n), .load_por(sys_rst && first_boot),
        .wr_en(wr_hit), .wdata(bus_wdata),
        .btn_por(btn_por), .btn_xir(btn_xir), .q(status_q)
    );

    // One-cycle reset request after a soft request write
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= req_set;
    end

    // Read mux: register only on a matching read
    assign bus_rdata = rd_hit ? status_q : '0;
endmodule

// File: rtl/rcr_chk.sv
// Assertion checker bound to rst_cause_reg.
module rcr_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sys_rst,
    input logic              btn_por,
    input logic              btn_xir,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              rst_req,
    input logic [CNT_W-1:0]  cnt,
    input logic [31:0]       status
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    // R8
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    // R6
    req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(bus_sel && bus_wr && bus_addr[2] && (bus_wdata[30] || bus_wdata[29])));
    // R5
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[26:0] == 27'd0);
    // R9
    lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_addr[2]) |-> bus_rdata == 32'd0);
    // R11
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CMAX && !(bus_sel && bus_wr)) |=> cnt == CMAX);
    // R10
    btn_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
        btn_por |=> status[28]);
    // R10
    btn_xir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        btn_xir |=> status[27]);
    // R2
    por_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst && cnt == '0 && !bus_sel && !btn_por && !btn_xir) |=> status == 32'h8000_0000);
endmodule

bind rst_cause_reg rcr_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .btn_por(btn_por), .btn_xir(btn_xir),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_req(rst_req), .cnt(boot_cnt), .status(status_q)
);

// File: tb/tb_rst_cause_reg.sv
// Self-checking bench with a behavioural reference model compared every clock.
module tb_rst_cause_reg;
    localparam int CW   = 2;
    localparam int CMAX = (1 << CW) - 1;

    logic        clk = 1'b0, rst_n = 1'b0, sys_rst = 1'b0, btn_por = 1'b0, btn_xir = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_addr = 16'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int checks = 0, errors = 0, cyc = 0;
    string phase = "R1";
    logic [31:0] m_reg = 32'h0;
    int          m_cnt = 0;
    logic        m_req = 1'b0;

    rst_cause_reg #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .btn_por(btn_por), .btn_xir(btn_xir),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %08h exp %08h", tag, got, exp);
        end
    endtask

    // Reference model, updated from the inputs seen at each edge
    always @(posedge clk) begin
        logic hit; logic [31:0] n, v;
        if (!rst_n) begin
            m_reg = 0; m_cnt = 0; m_req = 0;
        end else begin
            hit = bus_sel && bus_wr && bus_addr[15:3] == 13'h1E04 && bus_addr[2];
            n = m_reg;
            if (sys_rst && m_cnt == 0) n = 32'h8000_0000;
            if (hit) begin
                v = bus_wdata & 32'hF800_0000;
                n = n & ~(v & 32'h9800_0000);
                n = n | (v & 32'h6000_0000);
            end
            if (btn_por) n[28] = 1'b1;
            if (btn_xir) n[27] = 1'b1;
            m_req = hit && (bus_wdata[30] || bus_wdata[29]);
            if (hit && bus_wdata[30]) m_cnt = 0;
            else if (sys_rst && m_cnt < CMAX) m_cnt++;
            m_reg = n;
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        logic [31:0] erd;
        if (rst_n) begin
            erd = (bus_sel && !bus_wr && bus_addr[15:3] == 13'h1E04 && bus_addr[2]) ? m_reg : 32'h0;
            check({phase, " rdata"}, bus_rdata, erd);
            check("R8 rst_req", {31'd0, rst_req}, {31'd0, m_req});
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog got hang exp done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic exp_req, input string tag);
        @(posedge clk); #2;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_sel = 0; bus_wr = 0; bus_wdata = 0;
        @(negedge clk);
        check({tag, " req"}, {31'd0, rst_req}, {31'd0, exp_req});
        if (exp_req) begin
            @(negedge clk);
            check("R8 pulse width", {31'd0, rst_req}, 32'd0);
        end
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #2;
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        check(tag, bus_rdata, exp);
        @(posedge clk); #2;
        bus_sel = 0;
    endtask

    task automatic pulse_sys;
        @(posedge clk); #2; sys_rst = 1;
        @(posedge clk); #2; sys_rst = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        phase = "R1";
        rd(16'hF024, 32'h0, "R1 reset value");
        check("R1 req after reset", {31'd0, rst_req}, 32'd0);

        phase = "R2";
        pulse_sys();
        rd(16'hF024, 32'h8000_0000, "R2 first boot load");

        phase = "R3";
        wr(16'hF024, 32'h0000_0000, 1'b0, "R3 zero write");
        rd(16'hF024, 32'h8000_0000, "R3 zero keeps bit31");
        wr(16'hF024, 32'h8000_0000, 1'b0, "R3 clear");
        rd(16'hF024, 32'h0, "R3 bit31 cleared");

        phase = "R10";
        @(posedge clk); #2; btn_por = 1; btn_xir = 1;
        @(posedge clk); #2; btn_por = 0; btn_xir = 0;
        rd(16'hF024, 32'h1800_0000, "R10 buttons set");
        phase = "R3";
        wr(16'hF024, 32'h1000_0000, 1'b0, "R3 clear b28");
        rd(16'hF024, 32'h0800_0000, "R3 b27 left");
        wr(16'hF024, 32'h0800_0000, 1'b0, "R3 clear b27");

        phase = "R7";
        wr(16'hF024, 32'h2000_0000, 1'b1, "R7 soft xir");
        rd(16'hF024, 32'h2000_0000, "R4 set b29");
        phase = "R4";
        wr(16'hF024, 32'h0000_0000, 1'b0, "R4 zero write");
        rd(16'hF024, 32'h2000_0000, "R4 b29 sticky");
        phase = "R7";
        pulse_sys();
        rd(16'hF024, 32'h2000_0000, "R7 no reload after xir");

        phase = "R5";
        wr(16'hF024, 32'h07FF_FFFF, 1'b0, "R5 low bits");
        rd(16'hF024, 32'h2000_0000, "R5 low bits ignored");

        phase = "R9";
        wr(16'hF020, 32'h4000_0000, 1'b0, "R9 low word write");
        rd(16'hF024, 32'h2000_0000, "R9 low word ignored");
        rd(16'hF020, 32'h0, "R9 low word reads 0");
        wr(16'h1024, 32'h4000_0000, 1'b0, "R9 other window write");
        rd(16'h1024, 32'h0, "R9 other window reads 0");
        rd(16'hF02C, 32'h0, "R9 next window reads 0");

        phase = "R6";
        wr(16'hF024, 32'h4000_0000, 1'b1, "R6 soft por");
        rd(16'hF024, 32'h6000_0000, "R6 b30 set");
        pulse_sys();
        rd(16'hF024, 32'h8000_0000, "R6 rearmed load");

        phase = "R10";
        @(posedge clk); #2;
        btn_por = 1; bus_sel = 1; bus_wr = 1; bus_addr = 16'hF024; bus_wdata = 32'h1000_0000;
        @(posedge clk); #2;
        btn_por = 0; bus_sel = 0; bus_wr = 0; bus_wdata = 0;
        rd(16'hF024, 32'h9000_0000, "R10 button beats clear");

        phase = "R11";
        wr(16'hF024, 32'h9000_0000, 1'b0, "R11 clear all");
        for (int i = 0; i < CMAX + 3; i++) pulse_sys();
        rd(16'hF024, 32'h0, "R11 saturated no reload");

        phase = "R1";
        @(posedge clk); #2 rst_n = 0;
        @(posedge clk); #2 rst_n = 1;
        rd(16'hF024, 32'h0, "R1 re-reset value");

        repeat (2) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule